// File: doc/BRIEF.md
# Video controller command port decoder

This block sits behind the 16-bit control port of a tile-based video controller. Each word written to the port is either a write to one of the controller's internal 8-bit registers, or one half of a two-word access setup. A setup chooses a target memory (pattern RAM, colour RAM or vertical-scroll RAM), the direction of access, a 16-bit access address and whether a DMA operation is wanted. The decoder keeps the assembled setup and the register file. It passes them to a data-port sequencer and to a separate DMA engine.

The data-port sequencer signals each data-port access. On each one the decoder advances the access address by the auto-increment register. The DMA engine receives a one-cycle request and reports completion. Between the two, the decoder shows a busy bit in the status word. A status read or a data-port access cancels a half-finished setup. A DMA request goes out only while the DMA enable bit in register 1 is set.

Top module: `vcmd_port`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: every register, the access address, the full 6-bit code, the busy bit and dma_req. The target then decodes as pattern-RAM read (acc_target=0, acc_write=0).
- R2: A control write with bits 15:14 = 2'b10 and no setup pending is a register write. Bits 12:8 give the index and bits 7:0 the value, and the value is visible from the next cycle. The register outputs map as follows: mode_a = register 0, mode_b = register 1, addr_step = register 15, dma_len = {register 20, register 19}, dma_src = {register 23, register 22, register 21}.
- R3: A register write whose index is NUM_REGS (default 24) or larger changes no register.
- R4: A control write with no setup pending and bits 15:14 other than 2'b10 is a first word. It loads code bits 1:0 from bits 15:14 and address bits 13:0 from bits 13:0, and it marks a setup pending. The next control write is then a second word, whatever its top bits. It loads address bits 15:14 from bits 1:0 and code bits 5:2 from bits 7:4, writes no register, and clears the pending mark.
- R5: Code bits 3:0 select the target: 0001 gives pattern-RAM write, 0011 colour-RAM write, 0101 scroll-RAM write, 0000 pattern-RAM read, 0100 scroll-RAM read and 1000 colour-RAM read. The target encoding is 0 for pattern RAM, 1 for colour RAM, 2 for scroll RAM and 3 for none, with acc_write=1 for a write. Any other code gives target 3 with acc_write=0.
- R6: A data-port access or a status read clears a pending setup, so a following control word with top bits 10 acts as a register write.
- R7: Each data-port access adds the value of register 15 to the access address, modulo 2^16.
- R8: A second word with bit 7 set while register 1 bit 4 is 1 raises dma_req for exactly one cycle, the cycle after that write. The busy bit is set from that same cycle.
- R9: While register 1 bit 4 is 0, a second word with bit 7 set raises no dma_req and leaves busy at 0.
- R10: Status bit 1 equals the busy bit and every other status bit is 0. Busy clears in the cycle after dma_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_data | input | 16 | Control-port write word |
| stat_rd | input | 1 | Status-read strobe |
| data_acc | input | 1 | Data-port access strobe from the sequencer |
| dma_done | input | 1 | DMA or fill operation finished |
| status_word | output | 16 | Status word; bit 1 is busy |
| acc_target | output | 2 | Decoded target memory |
| acc_write | output | 1 | Access is a write |
| acc_addr | output | 16 | Current access address |
| dma_req | output | 1 | One-cycle DMA request to the engine |
| mode_a | output | 8 | Register 0 |
| mode_b | output | 8 | Register 1 (bit 4 enables DMA) |
| addr_step | output | 8 | Register 15, the auto-increment |
| dma_len | output | 16 | DMA length, registers 20:19 |
| dma_src | output | 24 | DMA source, registers 23:21 |

## Verification
The hardest case to reach is a second word that looks like a register write. From the ports it can only be told apart by the register it does not change. The stimulus first loads register 0 with a known value. It then sends a first word and follows it with a second word whose top bits are 10 and whose index field points at register 0, and checks that register 0 still holds its value. The reverse case is also covered: a status read or a data access between the two words must turn the same kind of word back into a real register write. The address wrap at 0xFFFE is checked with both an even and an odd step.

// File: rtl/vcmd_pkg.sv
// Shared types for the control-port decoder: target encoding and code decode.
// Assumes code bits 3:0 alone select target and direction.
package vcmd_pkg;
    typedef enum logic [1:0] {
        TGT_PAT  = 2'd0,
        TGT_COL  = 2'd1,
        TGT_SCR  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e target;
        logic wr;
    } acc_t;

    function automatic acc_t decode_code(input logic [3:0] c);
        acc_t r;
        unique case (c)
            4'b0001: r = '{TGT_PAT,  1'b1};
            4'b0011: r = '{TGT_COL,  1'b1};
            4'b0101: r = '{TGT_SCR,  1'b1};
            4'b0000: r = '{TGT_PAT,  1'b0};
            4'b0100: r = '{TGT_SCR,  1'b0};
            4'b1000: r = '{TGT_COL,  1'b0};
            default: r = '{TGT_NONE, 1'b0};
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vcmd_regfile.sv
// Internal 8-bit register file. Writes whose index is at or above NUM_REGS
// are dropped. Assumes the index field is IDX_W bits wide and NUM_REGS <= 2**IDX_W.
module vcmd_regfile #(
    parameter int NUM_REGS = 24,
    parameter int IDX_W    = 5,
    parameter int DW       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DW-1:0]          wdata,
    output logic [NUM_REGS*DW-1:0] regs_flat
);
    localparam int IDX_LIM = NUM_REGS;

    logic in_range;
    // Qualify the index against the implemented register count.
    always_comb in_range = (32'(idx) < IDX_LIM);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DW-1:0] q;
        // One register: load on a matching in-range write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && in_range && (32'(idx) == g))
                q <= wdata;
        end
        assign regs_flat[g*DW +: DW] = q;
    end

    a_r3_ignore_high_index: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (32'(idx) >= IDX_LIM)) |=> $stable(regs_flat));
endmodule

// File: rtl/vcmd_access.sv
// Two-word access setup: holds the pending mark, the 6-bit code and the
// access address, and advances the address on data-port accesses.
// Assumes the top level decides which control writes are register writes.
module vcmd_access #(
    parameter int AW   = 16,
    parameter int CW   = 6,
    parameter int STEP = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [15:0]     ctl_data,
    input  logic            reg_wr,
    input  logic            data_acc,
    input  logic            stat_rd,
    input  logic [STEP-1:0] step,
    output logic            pending,
    output logic            sec_stb,
    output logic [AW-1:0]   addr,
    output logic [CW-1:0]   code
);
    localparam int LOW_AW = AW - 2;

    logic first_stb;
    // Classify the current control write.
    always_comb begin
        sec_stb   = ctl_wr && pending;
        first_stb = ctl_wr && !pending && !reg_wr;
    end

    // Pending mark: set by a first word, cleared by a second word or port access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (first_stb)
            pending <= 1'b1;
        else if (sec_stb || (!ctl_wr && (data_acc || stat_rd)))
            pending <= 1'b0;
    end

    // Address and code assembly, plus auto-increment on data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            code <= '0;
        end else if (first_stb) begin
            addr[LOW_AW-1:0] <= ctl_data[LOW_AW-1:0];
            code[1:0]        <= ctl_data[15:14];
        end else if (sec_stb) begin
            addr[AW-1:LOW_AW] <= ctl_data[1:0];
            code[CW-1:2]      <= ctl_data[7:4];
        end else if (data_acc) begin
            addr <= addr + AW'(step);
        end
    end

    a_r4_second_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ctl_wr) |=> !pending);
    a_r6_access_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && (data_acc || stat_rd)) |=> !pending);
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr && data_acc) |=> (addr == $past(addr) + AW'($past(step))));
endmodule

// File: rtl/vcmd_dma_gate.sv
// DMA request gating and busy tracking. A request is issued only when the
// enable bit is set; busy holds until the engine reports completion.
module vcmd_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_stb,
    input  logic dma_bit,
    input  logic enable,
    input  logic dma_done,
    output logic dma_req,
    output logic busy
);
    logic fire;
    // A second word asking for DMA while enabled fires a request.
    always_comb fire = sec_stb && dma_bit && enable;

    // Request pulse and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_req <= 1'b0;
            busy    <= 1'b0;
        end else begin
            dma_req <= fire;
            if (fire)
                busy <= 1'b1;
            else if (dma_done)
                busy <= 1'b0;
        end
    end

    a_r9_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(enable));
    a_r8_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> busy);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);
    a_r10_fall_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(dma_done));
endmodule

// File: rtl/vcmd_port.sv
// Control-port decoder top: splits register writes from access setups,
// exposes the register file and the assembled access, gates DMA requests
// and forms the status word. Assumes one port strobe per cycle.
module vcmd_port #(
    parameter int NUM_REGS = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_data,
    input  logic        stat_rd,
    input  logic        data_acc,
    input  logic        dma_done,
    output logic [15:0] status_word,
    output logic [1:0]  acc_target,
    output logic        acc_write,
    output logic [15:0] acc_addr,
    output logic        dma_req,
    output logic [7:0]  mode_a,
    output logic [7:0]  mode_b,
    output logic [7:0]  addr_step,
    output logic [15:0] dma_len,
    output logic [23:0] dma_src
);
    import vcmd_pkg::*;

    localparam int DW       = 8;
    localparam int IDX_W    = 5;
    localparam int R_MODE_A = 0;
    localparam int R_MODE_B = 1;
    localparam int R_STEP   = 15;
    localparam int R_LEN    = 19;
    localparam int R_SRC    = 21;
    localparam int EN_BIT   = 4;

    logic [NUM_REGS*DW-1:0] regs_flat;
    logic                   pending, sec_stb, reg_wr, busy;
    logic [5:0]             code;
    acc_t                   acc;

    // Register write: top bits 10 with no setup pending.
    always_comb reg_wr = ctl_wr && !pending && (ctl_data[15:14] == 2'b10);

    vcmd_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_wr), .idx(ctl_data[12:8]),
        .wdata(ctl_data[7:0]), .regs_flat(regs_flat)
    );

    vcmd_access #(.AW(16), .CW(6), .STEP(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .reg_wr(reg_wr), .data_acc(data_acc), .stat_rd(stat_rd),
        .step(addr_step), .pending(pending), .sec_stb(sec_stb),
        .addr(acc_addr), .code(code)
    );

    vcmd_dma_gate u_dma (
        .clk(clk), .rst_n(rst_n), .sec_stb(sec_stb), .dma_bit(ctl_data[7]),
        .enable(mode_b[EN_BIT]), .dma_done(dma_done),
        .dma_req(dma_req), .busy(busy)
    );

    // Register views and decoded access.
    always_comb begin
        mode_a      = regs_flat[R_MODE_A*DW +: DW];
        mode_b      = regs_flat[R_MODE_B*DW +: DW];
        addr_step   = regs_flat[R_STEP*DW +: DW];
        dma_len     = regs_flat[R_LEN*DW +: 2*DW];
        dma_src     = regs_flat[R_SRC*DW +: 3*DW];
        acc         = decode_code(code[3:0]);
        acc_target  = acc.target;
        acc_write   = acc.wr;
        status_word = {14'd0, busy, 1'b0};
    end

    a_r5_write_has_target: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write |-> (acc_target != TGT_NONE));
    a_r2_second_not_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_stb && ctl_data[15:14] == 2'b10 && ctl_data[12:8] == 5'd0) |=> $stable(mode_a));
endmodule

// File: tb/sim_vcmd_port.sv
module sim_vcmd_port;
    logic clk = 0, rst_n = 0;
    logic ctl_wr = 0, stat_rd = 0, data_acc = 0, dma_done = 0;
    logic [15:0] ctl_data = 0;
    logic [15:0] status_word, acc_addr, dma_len;
    logic [1:0]  acc_target;
    logic        acc_write, dma_req;
    logic [7:0]  mode_a, mode_b, addr_step;
    logic [23:0] dma_src;

    int checks = 0, errors = 0, cyc = 0;

    vcmd_port u0 (.*);

    always #2.5 clk = ~clk;

    // Behavioural reference model
    int m_reg [32];
    int m_addr, m_code, m_pend, m_busy, m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) m_reg[i] <= 0;
            m_addr <= 0; m_code <= 0; m_pend <= 0; m_busy <= 0; m_req <= 0;
        end else begin
            m_req <= 0;
            if (ctl_wr) begin
                if (m_pend != 0) begin
                    m_addr <= (m_addr % 16384) + (ctl_data % 4) * 16384;
                    m_code <= (m_code % 4) + ((ctl_data / 16) % 16) * 4;
                    m_pend <= 0;
                    if (ctl_data[7] && ((m_reg[1] / 16) % 2 == 1)) begin
                        m_req <= 1; m_busy <= 1;
                    end else if (dma_done) m_busy <= 0;
                end else if (ctl_data / 16384 == 2) begin
                    if ((ctl_data / 256) % 32 < 24) m_reg[(ctl_data / 256) % 32] <= ctl_data % 256;
                    if (dma_done) m_busy <= 0;
                end else begin
                    m_addr <= (m_addr / 16384) * 16384 + ctl_data % 16384;
                    m_code <= (m_code / 4) * 4 + ctl_data / 16384;
                    m_pend <= 1;
                    if (dma_done) m_busy <= 0;
                end
            end else begin
                if (data_acc || stat_rd) m_pend <= 0;
                if (data_acc) m_addr <= (m_addr + m_reg[15]) % 65536;
                if (dma_done) m_busy <= 0;
            end
        end
    end

    function automatic int exp_tgt(int c);
        case (c % 16)
            1, 0: return 0;
            3, 8: return 1;
            5, 4: return 2;
            default: return 3;
        endcase
    endfunction
    function automatic int exp_wr(int c);
        return (c % 16 == 1 || c % 16 == 3 || c % 16 == 5) ? 1 : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R7 model addr", acc_addr, m_addr);
            chk("R5 model target", acc_target, exp_tgt(m_code));
            chk("R5 model write", acc_write, exp_wr(m_code));
            chk("R10 model status", status_word, m_busy * 2);
            chk("R8 model req", dma_req, m_req);
            chk("R2 model mode_a", mode_a, m_reg[0]);
            chk("R2 model mode_b", mode_b, m_reg[1]);
            chk("R2 model step", addr_step, m_reg[15]);
            chk("R2 model len", dma_len, m_reg[20] * 256 + m_reg[19]);
            chk("R2 model src", dma_src, (m_reg[23] * 256 + m_reg[22]) * 256 + m_reg[21]);
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic ctl(input logic [15:0] w);
        @(negedge clk); ctl_data = w; ctl_wr = 1;
        @(negedge clk); ctl_wr = 0;
    endtask
    task automatic dacc();
        @(negedge clk); data_acc = 1;
        @(negedge clk); data_acc = 0;
    endtask
    task automatic srd();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask
    task automatic setup(input logic [15:0] w1, input logic [15:0] w2);
        ctl(w1); ctl(w2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr", acc_addr, 0);
        chk("R1 target", acc_target, 0);
        chk("R1 write", acc_write, 0);
        chk("R1 status", status_word, 0);
        chk("R1 dma_req", dma_req, 0);
        chk("R1 mode_b", mode_b, 0);

        // R2 register writes
        ctl(16'h8F02); ctl(16'h8014); ctl(16'h9334); ctl(16'h9412);
        ctl(16'h9501); ctl(16'h9602); ctl(16'h9703);
        chk("R2 step", addr_step, 8'h02);
        chk("R2 mode_a", mode_a, 8'h14);
        chk("R2 len", dma_len, 16'h1234);
        chk("R2 src", dma_src, 24'h030201);

        // R3 out-of-range indices
        ctl(16'h9855); ctl(16'h9F77);
        chk("R3 mode_a", mode_a, 8'h14);
        chk("R3 src", dma_src, 24'h030201);
        chk("R3 step", addr_step, 8'h02);

        // R4 two-word setup
        setup(16'h5234, 16'h0000);
        chk("R4 addr low", acc_addr, 16'h1234);
        chk("R5 pat write", acc_target * 2 + acc_write, 1);
        setup(16'h5234, 16'h0002);
        chk("R4 addr high", acc_addr, 16'h9234);

        // R5 code table
        setup(16'hC000, 16'h0000); chk("R5 col write", acc_target * 2 + acc_write, 3);
        setup(16'h4000, 16'h0010); chk("R5 scr write", acc_target * 2 + acc_write, 5);
        setup(16'h0000, 16'h0000); chk("R5 pat read", acc_target * 2 + acc_write, 0);
        setup(16'h0000, 16'h0010); chk("R5 scr read", acc_target * 2 + acc_write, 4);
        setup(16'h0000, 16'h0020); chk("R5 col read", acc_target * 2 + acc_write, 2);
        setup(16'hC000, 16'h0010); chk("R5 bad code", acc_target * 2 + acc_write, 6);

        // R4 second word with register-write top bits
        setup(16'h4000, 16'h8000);
        chk("R4 no reg write", mode_a, 8'h14);
        ctl(16'h8021);
        chk("R4 pending cleared", mode_a, 8'h21);

        // R6 cancel by status read and by data access
        ctl(16'h4100); srd(); ctl(16'h8F04);
        chk("R6 stat cancel", addr_step, 8'h04);
        ctl(16'h4100); dacc(); ctl(16'h8F02);
        chk("R6 data cancel", addr_step, 8'h02);
        chk("R7 step after cancel", acc_addr, 16'h0104);

        // R7 wrap with even and odd step
        setup(16'h7FFE, 16'h0003);
        chk("R7 setup", acc_addr, 16'hFFFE);
        dacc(); chk("R7 wrap even", acc_addr, 16'h0000);
        ctl(16'h8F03); setup(16'h7FFE, 16'h0003);
        dacc(); chk("R7 wrap odd", acc_addr, 16'h0001);
        dacc(); chk("R7 odd step", acc_addr, 16'h0004);

        // R9 gating
        ctl(16'h8100);
        setup(16'h4000, 16'h0080);
        chk("R9 no req", dma_req, 0);
        chk("R9 no busy", status_word, 0);

        // R8 and R10 request and completion
        ctl(16'h8110);
        setup(16'h4000, 16'h0080);
        chk("R8 req", dma_req, 1);
        chk("R10 busy", status_word, 16'h0002);
        @(negedge clk);
        chk("R8 pulse ends", dma_req, 0);
        chk("R10 busy holds", status_word, 16'h0002);
        dma_done = 1; @(negedge clk); dma_done = 0;
        chk("R10 busy cleared", status_word, 0);

        repeat (3) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule